// File: doc/BRIEF.md
# Tri-State Phase Comparator with Lock Indication

This block compares the timing of two edge streams, a reference stream and a feedback stream. It produces a three-state steering signal for a loop filter. When a reference rising edge arrives first, the output is driven high until the matching feedback edge arrives. When a feedback rising edge arrives first, the output is driven low until the matching reference edge arrives. While no edge is waiting for its partner, the output is released. The three-state pin is modelled as a data value (`pc_out`) plus an output enable (`pc_oe`).

Both compared inputs are sampled by one fast system clock. A rising-edge detector sits on each input. Each detected edge sets a pending flag for its own stream. When both flags would be set, both clear in that same cycle. A lock indication is high whenever nothing is pending, so it drops for the length of each phase-error pulse. The outputs change one clock edge after the input change that causes them. All pins are plain control and status signals, so no valid/ready handshake applies.

Top module: `tristate_pfd`

## Requirements
- R1: A synchronous active-high `rst` clears all pending state. At the clock edge where `rst` is sampled high, the outputs become `pc_oe`=0, `pc_out`=0 and `lock_det`=1.
- R2: Only rising edges (a 0 in the previous cycle, 1 in this cycle) of `ref_in` and `fb_in` have an effect. Falling edges and steady levels leave all outputs unchanged.
- R3: If a `ref_in` rising edge is seen in cycle i and a `fb_in` rising edge in a later cycle j, then `pc_oe`=1 and `pc_out`=1 after clock edges i through j-1. The pulse is exactly j-i cycles wide.
- R4: If a `fb_in` rising edge is seen in cycle j and a `ref_in` rising edge in a later cycle i, then `pc_oe`=1 and `pc_out`=0 after clock edges j through i-1. The pulse is exactly i-j cycles wide.
- R5: While no edge is pending, the output is released: `pc_oe`=0 and `pc_out`=0.
- R6: `lock_det` is 1 exactly when the output is released, and 0 for every cycle of a phase-error pulse.
- R7: Rising edges on both inputs in the same clock cycle produce no pulse. The output stays released and `lock_det` stays 1.
- R8: Further rising edges of the stream that is already pending do not accumulate. A single edge of the other stream ends the pulse, and the output then stays released.
- R9: An input that is already high while `rst` is asserted does not count as a rising edge when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference edge stream (synchronous to clk) |
| fb_in | input | 1 | Feedback edge stream (synchronous to clk) |
| pc_out | output | 1 | Phase output value: 1 when the reference leads, 0 otherwise |
| pc_oe | output | 1 | Phase output enable: 0 means the output is released |
| lock_det | output | 1 | High while no edge is pending |

## Verification
The bench sweeps every pair of edge arrival times within a small window. It then compares the width and polarity of the pulse, cycle by cycle, with the arithmetic difference of the two times. An off-by-one in pulse length, a swapped polarity, or a design that emits a one-cycle glitch when both edges land in the same cycle shows up in that sweep. Directed sequences target the remaining corners. Falling edges must not end a pulse. A level held high through reset must not look like a fresh edge. A repeated edge on the leading stream must not leave a residual pending edge behind; if it did, the output would be re-driven after the partner edge arrived.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int NUM_STREAMS = 2;
  localparam int IDX_REF = 0;
  localparam int IDX_FB  = 1;

  typedef enum logic [1:0] {
    DRV_OFF = 2'b00,
    DRV_HI  = 2'b01,
    DRV_LO  = 2'b10
  } drive_e;
endpackage

// File: rtl/pfd_edge_rise.sv
module pfd_edge_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  // The history register tracks the input even during reset, so a level
  // held high through reset is never seen as a new edge (R9).
  for (genvar g = 0; g < W; g++) begin : g_lane
    logic prev_q;
    always_ff @(posedge clk) prev_q <= sig[g];
    assign rise[g] = sig[g] & ~prev_q;
  end
endmodule

// File: rtl/pfd_flags.sv
module pfd_flags (
  input  logic clk,
  input  logic rst,
  input  logic rise_ref,
  input  logic rise_fb,
  output logic ref_pend,
  output logic fb_pend
);
  logic ref_nx, fb_nx, both_nx;

  always_comb begin
    ref_nx  = ref_pend | rise_ref;
    fb_nx   = fb_pend  | rise_fb;
    both_nx = ref_nx & fb_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_pend <= 1'b0;
      fb_pend  <= 1'b0;
    end else if (both_nx) begin
      ref_pend <= 1'b0;
      fb_pend  <= 1'b0;
    end else begin
      ref_pend <= ref_nx;
      fb_pend  <= fb_nx;
    end
  end

  // The two pending flags are never set at the same time (R5).
  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(ref_pend && fb_pend));

  // Edges in the same cycle with nothing pending leave both flags clear (R7).
  p_coincident_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (rise_ref && rise_fb && !ref_pend && !fb_pend) |=> (!ref_pend && !fb_pend));

  // A lone reference edge with nothing pending opens a pulse (R3).
  p_ref_opens_r3: assert property (@(posedge clk) disable iff (rst)
    (rise_ref && !rise_fb && !fb_pend) |=> ref_pend);

  // A lone feedback edge with nothing pending opens a pulse (R4).
  p_fb_opens_r4: assert property (@(posedge clk) disable iff (rst)
    (rise_fb && !rise_ref && !ref_pend) |=> fb_pend);

  // A second reference edge while reference is pending keeps only one pending (R8).
  p_no_accumulate_r8: assert property (@(posedge clk) disable iff (rst)
    (ref_pend && rise_ref && !rise_fb) |=> (ref_pend && !fb_pend));
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
  import pfd_pkg::*;
(
  input  logic ref_pend,
  input  logic fb_pend,
  output logic pc_out,
  output logic pc_oe,
  output logic lock_det
);
  drive_e drv;

  always_comb begin
    unique case ({fb_pend, ref_pend})
      2'b01:   drv = DRV_HI;
      2'b10:   drv = DRV_LO;
      default: drv = DRV_OFF;
    endcase
    pc_out   = (drv == DRV_HI);
    pc_oe    = (drv != DRV_OFF);
    lock_det = (drv == DRV_OFF);
  end
endmodule

// File: rtl/tristate_pfd.sv
module tristate_pfd
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic pc_out,
  output logic pc_oe,
  output logic lock_det
);
  logic [NUM_STREAMS-1:0] sig_bus;
  logic [NUM_STREAMS-1:0] rise_bus;
  logic ref_pend, fb_pend;

  assign sig_bus[IDX_REF] = ref_in;
  assign sig_bus[IDX_FB]  = fb_in;

  pfd_edge_rise #(.W(NUM_STREAMS)) u_edge (
    .clk  (clk),
    .sig  (sig_bus),
    .rise (rise_bus)
  );

  pfd_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .rise_ref (rise_bus[IDX_REF]),
    .rise_fb  (rise_bus[IDX_FB]),
    .ref_pend (ref_pend),
    .fb_pend  (fb_pend)
  );

  pfd_drive u_drive (
    .ref_pend (ref_pend),
    .fb_pend  (fb_pend),
    .pc_out   (pc_out),
    .pc_oe    (pc_oe),
    .lock_det (lock_det)
  );

  // Reset leaves the output released and lock asserted (R1).
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (lock_det && !pc_oe && !pc_out));

  // A feedback edge ends a high pulse (R3).
  p_high_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (pc_oe && pc_out && rise_bus[IDX_FB]) |=> !pc_oe);

  // A reference edge ends a low pulse (R4).
  p_low_ends_r4: assert property (@(posedge clk) disable iff (rst)
    (pc_oe && !pc_out && rise_bus[IDX_REF]) |=> !pc_oe);

  // With no rising edges the outputs hold (R2).
  p_hold_no_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (rise_bus == '0) |=> ($stable(pc_oe) && $stable(pc_out) && $stable(lock_det)));
endmodule

// File: tb/tristate_pfd_tb.sv
`timescale 1ns/1ps
module tristate_pfd_tb;
  localparam int SPAN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic pc_out, pc_oe, lock_det;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tristate_pfd u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .lock_det(lock_det)
  );

  task automatic chk(input bit e_out, input bit e_oe, input bit e_lock, input string tag);
    n_chk++;
    if (pc_out !== e_out || pc_oe !== e_oe || lock_det !== e_lock) begin
      n_bad++;
      $display("FAIL %s: out/oe/lock actual %b%b%b expected %b%b%b",
               tag, pc_out, pc_oe, lock_det, e_out, e_oe, e_lock);
    end
  endtask

  task automatic do_reset(input bit r_lvl, input bit f_lvl);
    @(negedge clk);
    rst = 1'b1; ref_in = r_lvl; fb_in = f_lvl;
    @(negedge clk);
    chk(1'b0, 1'b0, 1'b1, "R1 reset state");
    rst = 1'b0;
  endtask

  task automatic step_chk(input bit e_out, input bit e_oe, input string tag);
    @(negedge clk);
    chk(e_out, e_oe, !e_oe, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // Sweep: R3, R4, R5, R6, R7 over every pair of arrival cycles
    for (int da = 0; da <= SPAN; da++) begin
      for (int db = 0; db <= SPAN; db++) begin
        int last;
        last = ((da > db) ? da : db) + 3;
        do_reset(1'b0, 1'b0);
        for (int c = 0; c <= last; c++) begin
          if (c > 0) begin
            int t;
            bit e_hi, e_lo;
            t = c - 1;
            e_hi = (da < db) && (t >= da) && (t < db);
            e_lo = (db < da) && (t >= db) && (t < da);
            chk(e_hi, e_hi | e_lo, !(e_hi | e_lo),
                (da == db) ? "R7 coincident" : (e_hi ? "R3 lead" : (e_lo ? "R4 lag" : "R5/R6 released")));
          end
          ref_in = (c >= da);
          fb_in  = (c >= db);
          if (c < last) @(negedge clk);
        end
      end
    end

    // R9: reference held high through reset is not an edge
    do_reset(1'b1, 1'b0);
    step_chk(1'b0, 1'b0, "R9 held level after reset");
    step_chk(1'b0, 1'b0, "R9 held level after reset");
    fb_in = 1'b1;
    step_chk(1'b0, 1'b1, "R9 feedback alone drives low");

    // R2: falling edges have no effect
    do_reset(1'b0, 1'b0);
    ref_in = 1'b1; fb_in = 1'b1;
    step_chk(1'b0, 1'b0, "R2 both rise");
    ref_in = 1'b0;
    step_chk(1'b0, 1'b0, "R2 ref fall ignored");
    ref_in = 1'b1;
    step_chk(1'b1, 1'b1, "R2 ref rise drives high");
    fb_in = 1'b0;
    step_chk(1'b1, 1'b1, "R2 fb fall ignored");
    step_chk(1'b1, 1'b1, "R2 hold high");
    fb_in = 1'b1;
    step_chk(1'b0, 1'b0, "R2 fb rise releases");

    // R8: repeated leading edges do not accumulate
    do_reset(1'b0, 1'b0);
    ref_in = 1'b1;
    step_chk(1'b1, 1'b1, "R8 first ref edge");
    ref_in = 1'b0;
    step_chk(1'b1, 1'b1, "R8 ref low");
    ref_in = 1'b1;
    step_chk(1'b1, 1'b1, "R8 second ref edge");
    fb_in = 1'b1;
    step_chk(1'b0, 1'b0, "R8 single fb edge releases");
    step_chk(1'b0, 1'b0, "R8 no residual");
    step_chk(1'b0, 1'b0, "R8 no residual");

    // R8 mirrored on the feedback stream
    do_reset(1'b0, 1'b0);
    fb_in = 1'b1;
    step_chk(1'b0, 1'b1, "R8 first fb edge");
    fb_in = 1'b0;
    step_chk(1'b0, 1'b1, "R8 fb low");
    fb_in = 1'b1;
    step_chk(1'b0, 1'b1, "R8 second fb edge");
    ref_in = 1'b1;
    step_chk(1'b0, 1'b0, "R8 single ref edge releases");
    step_chk(1'b0, 1'b0, "R8 no residual");

    // R1: reset in the middle of a pulse
    do_reset(1'b0, 1'b0);
    ref_in = 1'b1;
    step_chk(1'b1, 1'b1, "R1 pulse before reset");
    do_reset(1'b1, 1'b0);
    step_chk(1'b0, 1'b0, "R1 released after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule